// File: doc/BRIEF.md
# Periodic Status Poll Watchdog

This block checks that a configuration-memory scrubbing controller is still alive. It sends a short status query on a byte-wide command channel at a programmable interval, then watches the byte stream that comes back for a status report. If no report arrives within a programmable timeout, it raises a sticky "controller unresponsive" flag. System logic treats that flag as an uncorrectable, essential error.

Polling happens only while the controller reports its observation state. In the idle state, other software may own the command channel, so the block does not poll. In any other state the controller would only hold the query. If the controller changes state while a query is outstanding, the query is dropped quietly and the interval starts again. This makes a legitimate state change distinguishable from a hung controller.

The interval should cover tens of seconds of clock cycles, around sixty seconds in practice. Polling faster fills the controller's report path with status traffic and delays its real event reports. The timeout is typically one second.

Top module: `status_poll_watchdog`

## Requirements
- R1: While reset is held, and in the first cycle after it, `tx_valid` and `unresponsive` are low.
- R2: The first query byte is offered exactly `cfg_period` cycles after reset release, or after a query ends, provided the controller stays in observation throughout. A `cfg_period` of 0 behaves as 1.
- R3: A query is the byte 0x53 followed by the byte 0x0D, each transferred on a cycle with `tx_valid` and `tx_ready` both high. While `tx_ready` is low, `tx_valid` stays high and `tx_data` holds its value.
- R4: No query starts unless `ctl_state` equals the observation code (default 0x04). The interval count restarts from zero on every cycle in which `ctl_state` differs from its previous value, and while the controller is outside observation. A state change therefore adds one cycle, so the query follows `cfg_period`+1 cycles after the change.
- R5: A report is a `cfg_start_byte` followed later, with any bytes between, by a `cfg_end_byte` on `rx_valid` cycles. A report whose end byte arrives on or before the last timeout cycle ends the query with no flag. An end byte with no start byte before it inside the query does not count.
- R6: If no report completes, `unresponsive` rises exactly `cfg_timeout` cycles after the last query byte transfers. A `cfg_timeout` of 0 behaves as 1.
- R7: A change of `ctl_state` while a report is awaited abandons the query without setting `unresponsive`. The interval then restarts.
- R8: `unresponsive` stays high until `clear_flag` is sampled high. A new timeout in the same cycle as `clear_flag` wins, and the flag stays set.
- R9: Received bytes count only while a query is awaiting its report. A start byte received before the query was sent does not take part in matching.
- R10: At most one query is outstanding. No query byte is offered while a report is being awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_period | input | CNT_W | Poll interval in cycles |
| cfg_timeout | input | CNT_W | Response timeout in cycles after the query is sent |
| cfg_start_byte | input | 8 | Byte that opens a status report |
| cfg_end_byte | input | 8 | Byte that closes a status report |
| ctl_state | input | STATE_W | Controller state indicators |
| clear_flag | input | 1 | Clears the unresponsive flag |
| tx_valid | output | 1 | Query byte offered |
| tx_ready | input | 1 | Command channel accepts the byte |
| tx_data | output | 8 | Query byte |
| rx_valid | input | 1 | A received report byte is present |
| rx_data | input | 8 | Received report byte |
| unresponsive | output | 1 | Sticky controller-unresponsive error flag |

## Verification
The matching function is tried with four receive patterns:
- A complete report sent promptly.
- A report whose end byte lands on the last timeout cycle.
- An end byte with no start byte.
- A start byte sent before the query, followed by a lone end byte inside it.

Together these separate a correct start-then-end match, an off-by-one timeout, a matcher that accepts a bare end byte, and one that keeps state across queries. Separately, state patterns are applied while the block waits and while a query is outstanding: an excursion to a correction state, a stay in idle, and a return to observation. These show whether gating, quiet cancellation and the interval restart behave differently from a plain timeout. Back-pressure on the command channel separates a transmitter that holds its byte from one that drops or advances it.

// File: rtl/spw_pkg.sv
// Shared types for the status poll watchdog.
// Assumes: nothing beyond a SystemVerilog 2017 tool.
package spw_pkg;

    // Phase of the poll cycle: counting the interval, sending the query,
    // waiting for the report.
    typedef enum logic [1:0] {
        PH_WAIT  = 2'd0,
        PH_SEND  = 2'd1,
        PH_AWAIT = 2'd2
    } spw_phase_e;

endpackage

// File: rtl/spw_limit_counter.sv
// Up-counter that flags the cycle in which it has reached a limit.
// What it does: counts enabled cycles from zero. When the count equals or
// exceeds `limit` in an enabled cycle, `hit` is high and the count returns
// to zero.
// Assumes: the owner clears it whenever the counted window is not active;
// `limit` is already the terminal count (period minus one).
module spw_limit_counter #(
    parameter int unsigned W = 34
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         hit
);

    logic [W-1:0] cnt;

    // Terminal condition for this cycle.
    always_comb begin
        hit = en && !clr && (cnt >= limit);
    end

    // Count register: cleared on request, wrapped to zero at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= hit ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/spw_query_tx.sv
// Two-byte query transmitter on a valid/ready byte channel.
// What it does: while `active` is high, it offers BYTE0 and then BYTE1.
// `done` marks the cycle in which BYTE1 is accepted.
// Assumes: `active` stays high until `done` and drops the cycle after it;
// the receiver may hold `tx_ready` low for any number of cycles.
module spw_query_tx #(
    parameter logic [7:0] BYTE0 = 8'h53,
    parameter logic [7:0] BYTE1 = 8'h0D
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       tx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       done
);

    logic second_q;
    logic xfer;

    // Byte selection and handshake decode.
    always_comb begin
        tx_valid = active;
        tx_data  = second_q ? BYTE1 : BYTE0;
        xfer     = active && tx_ready;
        done     = xfer && second_q;
    end

    // Byte index: advances only on an accepted byte, resets when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            second_q <= 1'b0;
        end else if (xfer) begin
            second_q <= !second_q;
        end
    end

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R3

endmodule

// File: rtl/spw_report_match.sv
// Status report recogniser on a received byte stream.
// What it does: while `arm` is high, it remembers a start byte and reports
// `found` on the first end byte after it. Everything is forgotten when
// `arm` drops.
// Assumes: `arm` is high exactly while a report is being awaited.
module spw_report_match (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic [7:0] start_byte,
    input  logic [7:0] end_byte,
    output logic       found
);

    logic opened_q;

    // Completion decode: end byte after an opening byte, while armed.
    always_comb begin
        found = arm && rx_valid && opened_q && (rx_data == end_byte);
    end

    // Opening tracker: set by a start byte while armed, cleared when disarmed.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm) begin
            opened_q <= 1'b0;
        end else if (rx_valid && (rx_data == start_byte)) begin
            opened_q <= 1'b1;
        end
    end

    AST_OPEN_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> !opened_q); // R9

endmodule

// File: rtl/status_poll_watchdog.sv
// Periodic status poll watchdog for a scrubbing controller.
// What it does: in the observation state, it counts the poll interval and
// sends a two-byte query. It then waits for a start/end delimited report
// and flags the controller unresponsive if the timeout runs out. A change
// of controller state cancels the outstanding query quietly.
// Assumes: the configuration inputs are static between queries; a state
// change during the query transmission is honoured once both bytes have
// gone out, because valid is never withdrawn.
module status_poll_watchdog
    import spw_pkg::*;
#(
    parameter int unsigned          CNT_W        = 34,
    parameter int unsigned          STATE_W      = 7,
    parameter logic [STATE_W-1:0]   OBSERVE_CODE = STATE_W'(4),
    parameter logic [7:0]           QUERY_CHAR   = 8'h53,
    parameter logic [7:0]           TERM_CHAR    = 8'h0D
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   cfg_period,
    input  logic [CNT_W-1:0]   cfg_timeout,
    input  logic [7:0]         cfg_start_byte,
    input  logic [7:0]         cfg_end_byte,
    input  logic [STATE_W-1:0] ctl_state,
    input  logic               clear_flag,
    output logic               tx_valid,
    input  logic               tx_ready,
    output logic [7:0]         tx_data,
    input  logic               rx_valid,
    input  logic [7:0]         rx_data,
    output logic               unresponsive
);

    spw_phase_e         phase_q, phase_d;
    logic [STATE_W-1:0] state_prev_q;
    logic               in_observe;
    logic               state_moved;
    logic               cancel_q;
    logic [CNT_W-1:0]   period_lim;
    logic [CNT_W-1:0]   timeout_lim;
    logic               period_hit;
    logic               timeout_hit;
    logic               query_done;
    logic               report_found;
    logic               timeout_evt;
    logic               flag_q;

    // Terminal counts; a zero setting acts as one cycle.
    always_comb begin
        period_lim  = (cfg_period  == '0) ? '0 : cfg_period  - 1'b1;
        timeout_lim = (cfg_timeout == '0) ? '0 : cfg_timeout - 1'b1;
    end

    // Controller state decode and change detection.
    always_comb begin
        in_observe  = (ctl_state == OBSERVE_CODE);
        state_moved = (ctl_state != state_prev_q);
    end

    // Previous controller state, also loaded during reset.
    always_ff @(posedge clk) begin
        state_prev_q <= ctl_state;
    end

    spw_limit_counter #(.W(CNT_W)) u_period (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   ((phase_q != PH_WAIT) || !in_observe || state_moved),
        .en    ((phase_q == PH_WAIT) && in_observe && !state_moved),
        .limit (period_lim),
        .hit   (period_hit)
    );

    spw_limit_counter #(.W(CNT_W)) u_timeout (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (phase_q != PH_AWAIT),
        .en    (phase_q == PH_AWAIT),
        .limit (timeout_lim),
        .hit   (timeout_hit)
    );

    spw_query_tx #(.BYTE0(QUERY_CHAR), .BYTE1(TERM_CHAR)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (phase_q == PH_SEND),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .done     (query_done)
    );

    spw_report_match u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (phase_q == PH_AWAIT),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .start_byte (cfg_start_byte),
        .end_byte   (cfg_end_byte),
        .found      (report_found)
    );

    // Timeout counts only when neither a report nor a state change ended the wait.
    always_comb begin
        timeout_evt = (phase_q == PH_AWAIT) && timeout_hit && !report_found && !state_moved;
    end

    // Next phase of the poll cycle.
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_WAIT:  if (period_hit) phase_d = PH_SEND;
            PH_SEND:  if (query_done) phase_d = (cancel_q || state_moved) ? PH_WAIT : PH_AWAIT;
            PH_AWAIT: if (report_found || state_moved || timeout_hit) phase_d = PH_WAIT;
            default:  phase_d = PH_WAIT;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_WAIT;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Remembers a state change seen while the query bytes were going out.
    always_ff @(posedge clk) begin
        if (!rst_n || (phase_q != PH_SEND)) begin
            cancel_q <= 1'b0;
        end else if (state_moved) begin
            cancel_q <= 1'b1;
        end
    end

    // Sticky unresponsive flag; a new timeout beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (timeout_evt) begin
            flag_q <= 1'b1;
        end else if (clear_flag) begin
            flag_q <= 1'b0;
        end
    end

    assign unresponsive = flag_q;

    AST_POLL_IN_OBSERVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> ($past(ctl_state) == OBSERVE_CODE)); // R4
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_AWAIT) |-> !tx_valid); // R10
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (unresponsive && !clear_flag) |=> unresponsive); // R8
    AST_FLAG_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unresponsive) |-> ($past(phase_q) == PH_AWAIT)); // R6
    AST_CANCEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_q == PH_AWAIT) && state_moved && !unresponsive) |=> !unresponsive); // R7

endmodule

// File: tb/sim_status_poll_watchdog.sv
module sim_status_poll_watchdog;

    localparam int CW = 34;
    localparam int SW = 7;
    localparam int P  = 8;
    localparam int T  = 12;
    localparam logic [SW-1:0] ST_OBS  = 7'h04;
    localparam logic [SW-1:0] ST_CORR = 7'h08;
    localparam logic [SW-1:0] ST_IDLE = 7'h40;
    localparam logic [7:0] SB = 8'h3E;
    localparam logic [7:0] EB = 8'h0A;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cfg_period = CW'(P);
    logic [CW-1:0] cfg_timeout = CW'(T);
    logic [7:0]    cfg_start_byte = SB;
    logic [7:0]    cfg_end_byte = EB;
    logic [SW-1:0] ctl_state = ST_OBS;
    logic          clear_flag = 1'b0;
    logic          tx_valid;
    logic          tx_ready = 1'b1;
    logic [7:0]    tx_data;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_data = 8'h00;
    logic          unresponsive;

    int checks = 0;
    int failures = 0;
    logic [7:0] exp_q[$];

    always #4 clk = !clk;

    status_poll_watchdog #(.CNT_W(CW), .STATE_W(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_timeout(cfg_timeout),
        .cfg_start_byte(cfg_start_byte), .cfg_end_byte(cfg_end_byte),
        .ctl_state(ctl_state), .clear_flag(clear_flag),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_data(rx_data), .unresponsive(unresponsive)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Driver side of the scoreboard: one query expected.
    task automatic expect_query();
        exp_q.push_back(8'h53);
        exp_q.push_back(8'h0D);
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic poll_wait(output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (!tx_valid && n < 1000);
    endtask

    task automatic wait_query_done();
        for (int i = 0; i < 100 && tx_valid; i++) step();
    endtask

    task automatic rx_byte(input logic [7:0] b);
        rx_valid = 1'b1;
        rx_data  = b;
        step();
        rx_valid = 1'b0;
    endtask

    // Monitor side of the scoreboard: compare each accepted byte.
    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3", "unexpected query byte", tx_data, -1);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(tx_data == e, "R3", "query byte", tx_data, e);
            end
        end
    end

    initial begin
        #(8 * 150000);
        chk(1'b0, "watchdog", "run did not finish", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        bit bad;
        // R1: reset state
        repeat (3) step();
        chk(tx_valid == 1'b0, "R1", "tx_valid in reset", tx_valid, 0);
        chk(unresponsive == 1'b0, "R1", "flag in reset", unresponsive, 0);
        expect_query();
        @(posedge clk);
        #1 rst_n = 1'b1;
        // R2: first query after P cycles
        poll_wait(n);
        chk(n == P, "R2", "cycles to first query", n, P);
        wait_query_done();
        // R5: prompt complete report
        rx_byte(SB);
        rx_byte(8'h61);
        rx_byte(EB);
        expect_query();
        tx_ready = 1'b0;
        poll_wait(n);
        chk(n == P, "R2", "interval after report", n, P);
        chk(unresponsive == 1'b0, "R5", "flag after prompt report", unresponsive, 0);
        // R3: back-pressure holds the byte
        bad = 0;
        for (int i = 0; i < 4; i++) begin
            step();
            if (!tx_valid || tx_data != 8'h53) bad = 1;
        end
        chk(!bad, "R3", "hold under back-pressure", bad, 0);
        tx_ready = 1'b1;
        step();
        wait_query_done();
        // R5: end byte on the last timeout cycle
        rx_byte(SB);
        bad = 0;
        for (int i = 0; i < T - 2; i++) begin
            step();
            if (tx_valid) bad = 1;
        end
        chk(!bad, "R10", "no query while awaiting", bad, 0);
        rx_byte(EB);
        chk(unresponsive == 1'b0, "R5", "report on last timeout cycle", unresponsive, 0);
        // R6: timeout with no report
        expect_query();
        poll_wait(n);
        chk(n == P, "R2", "interval after late report", n, P);
        wait_query_done();
        for (int i = 0; i < T - 1; i++) step();
        chk(unresponsive == 1'b0, "R6", "flag one cycle before timeout", unresponsive, 0);
        step();
        chk(unresponsive == 1'b1, "R6", "flag at timeout", unresponsive, 1);
        // R8: sticky and clear
        expect_query();
        poll_wait(n);
        chk(unresponsive == 1'b1, "R8", "flag sticky", unresponsive, 1);
        wait_query_done();
        clear_flag = 1'b1;
        step();
        clear_flag = 1'b0;
        chk(unresponsive == 1'b0, "R8", "flag cleared", unresponsive, 0);
        for (int i = 0; i < T - 2; i++) step();
        clear_flag = 1'b1;
        step();
        chk(unresponsive == 1'b1, "R8", "timeout beats clear", unresponsive, 1);
        step();
        clear_flag = 1'b0;
        chk(unresponsive == 1'b0, "R8", "clear next cycle", unresponsive, 0);
        // R9: start byte before the query is forgotten; R5 lone end byte
        rx_byte(SB);
        expect_query();
        poll_wait(n);
        wait_query_done();
        rx_byte(EB);
        for (int i = 0; i < T - 2; i++) step();
        chk(unresponsive == 1'b0, "R9", "flag before timeout", unresponsive, 0);
        step();
        chk(unresponsive == 1'b1, "R9", "lone end byte times out", unresponsive, 1);
        clear_flag = 1'b1;
        step();
        clear_flag = 1'b0;
        // R7: state change cancels the outstanding query
        expect_query();
        poll_wait(n);
        wait_query_done();
        ctl_state = ST_CORR;
        bad = 0;
        for (int i = 0; i < 2 * T; i++) begin
            step();
            if (unresponsive || tx_valid) bad = 1;
        end
        chk(!bad, "R7", "cancel without flag", bad, 0);
        // R4: no polls in idle
        ctl_state = ST_IDLE;
        bad = 0;
        for (int i = 0; i < 3 * P; i++) begin
            step();
            if (tx_valid) bad = 1;
        end
        chk(!bad, "R4", "no query while idle", bad, 0);
        ctl_state = ST_OBS;
        expect_query();
        poll_wait(n);
        chk(n == P + 1, "R4", "interval restart after state change", n, P + 1);
        chk(unresponsive == 1'b0, "R7", "flag after cancel", unresponsive, 0);
        wait_query_done();
        // R2: period zero acts as one
        cfg_period = '0;
        rx_byte(SB);
        rx_byte(EB);
        expect_query();
        poll_wait(n);
        chk(n == 1, "R2", "zero period interval", n, 1);
        wait_query_done();
        rx_byte(SB);
        rx_byte(EB);
        step();
        chk(exp_q.size() == 0, "R3", "all query bytes sent", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule